// File: doc/BRIEF.md
# AES Column Mixing Unit

This block applies the AES column-mixing step to one 32-bit state column. The column holds four bytes that are read as the coefficients of a polynomial over GF(2^8). That polynomial is multiplied by the fixed polynomial {03}x^3 + {01}x^2 + {01}x + {02}, modulo x^4 + 1. Each output byte is the XOR of one input byte doubled in the field, its next neighbour tripled, and the two remaining bytes unchanged.

The only field products the block needs are by {02} and {03}, so it uses fixed XOR networks instead of general multipliers. Doubling is a one-place left shift followed by a conditional XOR with the reduction constant. Tripling adds the original byte to the doubled value. The worst-case depth is therefore a few 2-input XOR levels.

A column arrives with a valid flag. By default the result leaves through an output register, one cycle later. The `REG_OUT` parameter set to 0 removes that register and gives a purely combinational path.

Top module: `mixcol_unit`

## Requirements
- R1: While `rst_n` is low and after its release, with no column presented, `mix_valid_o` is 0 and `mix_data_o` is 0.
- R2: Doubling of a byte v is `{v[6:0],0}` when v[7] is 0, and `{v[6:0],0} ^ 8'h1B` when v[7] is 1. Examples: 57→ae, 80→1b, ff→e5.
- R3: Tripling of a byte v equals its doubled value XOR v. Examples: 57→f9, 80→9b, ff→1a.
- R4: Byte s0 sits in bits 31:24 and s3 in bits 7:0, and the output uses the same order. The output bytes are:
  - out0 = 2·s0 ^ 3·s1 ^ s2 ^ s3
  - out1 = s0 ^ 2·s1 ^ 3·s2 ^ s3
  - out2 = s0 ^ s1 ^ 2·s2 ^ 3·s3
  - out3 = 3·s0 ^ s1 ^ s2 ^ 2·s3
- R5: With `REG_OUT`=1, a column presented with `col_valid_i`=1 at a rising edge appears on `mix_data_o` with `mix_valid_o`=1 after that edge, and not before it. A cycle without input valid gives `mix_valid_o`=0 after the next edge.
- R6: With `REG_OUT`=1, `mix_data_o` keeps its last value while `col_valid_i` is 0, whatever is on `col_data_i`.
- R7: Columns presented on consecutive cycles each produce their own result on consecutive cycles, in order.
- R8: The input column db 13 53 45 yields 8e 4d a1 bc. The column f2 0a 22 5c yields 9f dc 58 9d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_valid_i | input | 1 | Input column is valid |
| col_data_i | input | 32 | Input column, s0 in bits 31:24 |
| mix_valid_o | output | 1 | Mixed column is valid |
| mix_data_o | output | 32 | Mixed column, same byte order |

## Verification
Columns with a single nonzero byte isolate the coefficient each output byte applies to each position. With the byte placed first, the coefficients show up directly. With the byte moved to the third position, the bench checks that the coefficient pattern rotates and that the byte order is right. Byte values with the top bit clear and set separate the plain shift from the reduced case of doubling. The published test columns, together with an unbroken stream against a bench-side model, cover the full XOR combination, back-to-back throughput and holding while idle.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
    localparam int GF_WIDTH  = 8;
    localparam int COL_BYTES = 4;
    localparam int COL_WIDTH = GF_WIDTH * COL_BYTES;
    localparam logic [GF_WIDTH-1:0] GF_RED_POLY = 8'h1B;
    typedef logic [GF_WIDTH-1:0] gf_elem_t;
endpackage

// File: rtl/gf_xtime_mul.sv
module gf_xtime_mul #(
    parameter int              W   = 8,
    parameter logic [W-1:0]    RED = 8'h1B
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] dbl_o,
    output logic [W-1:0] tpl_o
);
    // shift up one place; fold the dropped top bit back through the reduction constant (R2)
    always_comb begin
        dbl_o = {a_i[W-2:0], 1'b0} ^ (a_i[W-1] ? RED : '0);
        tpl_o = dbl_o ^ a_i;   // (x+1)*a (R3)
    end
endmodule

// File: rtl/mixcol_row.sv
module mixcol_row #(
    parameter int W   = 8,
    parameter int N   = 4,
    parameter int ROW = 0
) (
    input  logic [N-1:0][W-1:0] s_i,
    input  logic [N-1:0][W-1:0] dbl_i,
    input  logic [N-1:0][W-1:0] tpl_i,
    output logic [W-1:0]        row_o
);
    localparam int IDX_DBL = ROW % N;
    localparam int IDX_TPL = (ROW + 1) % N;

    always_comb begin
        row_o = dbl_i[IDX_DBL] ^ tpl_i[IDX_TPL];
        for (int j = 2; j < N; j++) begin
            row_o = row_o ^ s_i[(ROW + j) % N];
        end
    end
endmodule

// File: rtl/mixcol_unit.sv
module mixcol_unit
    import mixcol_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 col_valid_i,
    input  logic [COL_WIDTH-1:0] col_data_i,
    output logic                 mix_valid_o,
    output logic [COL_WIDTH-1:0] mix_data_o
);
    logic [COL_BYTES-1:0][GF_WIDTH-1:0] s_in;
    logic [COL_BYTES-1:0][GF_WIDTH-1:0] s_dbl;
    logic [COL_BYTES-1:0][GF_WIDTH-1:0] s_tpl;
    logic [COL_BYTES-1:0][GF_WIDTH-1:0] s_mix;
    logic [COL_WIDTH-1:0]               mixed_word;
    logic [GF_WIDTH-1:0]                xor_in;
    logic [GF_WIDTH-1:0]                xor_out;

    // byte k of the column lives at the k-th byte from the top (R4)
    for (genvar k = 0; k < COL_BYTES; k++) begin : g_lane
        assign s_in[k] = col_data_i[COL_WIDTH-1-k*GF_WIDTH -: GF_WIDTH];

        gf_xtime_mul #(.W(GF_WIDTH), .RED(GF_RED_POLY)) u_xt (
            .a_i   (s_in[k]),
            .dbl_o (s_dbl[k]),
            .tpl_o (s_tpl[k])
        );

        mixcol_row #(.W(GF_WIDTH), .N(COL_BYTES), .ROW(k)) u_row (
            .s_i   (s_in),
            .dbl_i (s_dbl),
            .tpl_i (s_tpl),
            .row_o (s_mix[k])
        );

        assign mixed_word[COL_WIDTH-1-k*GF_WIDTH -: GF_WIDTH] = s_mix[k];
    end

    always_comb begin
        xor_in  = '0;
        xor_out = '0;
        for (int k = 0; k < COL_BYTES; k++) begin
            xor_in  = xor_in  ^ s_in[k];
            xor_out = xor_out ^ s_mix[k];
        end
    end

    // coefficients 2,3,1,1 sum to 1 in the field, so the byte-wise XOR of a column is preserved
    AST_XOR_INVARIANT: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_i |-> (xor_out == xor_in)); // R4

    if (REG_OUT) begin : g_reg
        logic                 valid_q;
        logic [COL_WIDTH-1:0] data_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                data_q  <= '0;
            end else begin
                valid_q <= col_valid_i;
                if (col_valid_i) begin
                    data_q <= mixed_word;
                end
            end
        end

        assign mix_valid_o = valid_q;
        assign mix_data_o  = data_q;

        AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            col_valid_i |=> mix_valid_o); // R5
        AST_IDLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            !col_valid_i |=> !mix_valid_o); // R5
        AST_DATA_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            col_valid_i |=> (mix_data_o == $past(mixed_word))); // R5
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !col_valid_i |=> $stable(mix_data_o)); // R6
    end else begin : g_comb
        assign mix_valid_o = col_valid_i;
        assign mix_data_o  = mixed_word;
    end
endmodule

// File: tb/tb_mixcol_unit.sv
module tb_mixcol_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        col_valid_i = 1'b0;
    logic [31:0] col_data_i = '0;
    logic        mix_valid_o;
    logic [31:0] mix_data_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mixcol_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .col_valid_i (col_valid_i),
        .col_data_i  (col_data_i),
        .mix_valid_o (mix_valid_o),
        .mix_data_o  (mix_data_o)
    );

    function automatic logic [7:0] m2(input logic [7:0] v);
        return v[7] ? ((v << 1) ^ 8'h1B) : (v << 1);
    endfunction

    function automatic logic [31:0] model(input logic [31:0] c);
        logic [7:0] a, b, d, e;
        a = c[31:24]; b = c[23:16]; d = c[15:8]; e = c[7:0];
        return {m2(a) ^ m2(b) ^ b ^ d ^ e,
                a ^ m2(b) ^ m2(d) ^ d ^ e,
                a ^ b ^ m2(d) ^ m2(e) ^ e,
                m2(a) ^ a ^ b ^ d ^ m2(e)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // drive one column, then check result one edge later and hold with garbage input
    task automatic apply(input string req, input logic [31:0] col, input logic [31:0] exp);
        @(negedge clk);
        col_valid_i = 1'b1;
        col_data_i  = col;
        check({req, " R5 pre-edge valid"}, {31'd0, mix_valid_o}, 32'd0);
        @(negedge clk);
        check({req, " R5 valid"}, {31'd0, mix_valid_o}, 32'd1);
        check(req, mix_data_o, exp);
        col_valid_i = 1'b0;
        col_data_i  = ~col;
        @(negedge clk);
        check("R5 idle valid", {31'd0, mix_valid_o}, 32'd0);
        check("R6 hold", mix_data_o, exp);
    endtask

    task automatic t_reset;
        #5;
        check("R1 valid in reset", {31'd0, mix_valid_o}, 32'd0);
        check("R1 data in reset", mix_data_o, 32'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, mix_valid_o}, 32'd0);
        check("R1 data after reset", mix_data_o, 32'd0);
    endtask

    task automatic t_single_byte;
        // byte in first position: out = {2v, v, v, 3v}
        apply("R2 R3 v=57", 32'h5700_0000, 32'hae57_57f9);
        apply("R2 R3 v=80", 32'h8000_0000, 32'h1b80_809b);
        apply("R2 R3 v=ff", 32'hff00_0000, 32'he5ff_ff1a);
        // byte in third position: out = {v, 3v, 2v, v}
        apply("R4 rotate v=80", 32'h0000_8000, 32'h809b_1b80);
        apply("R4 rotate v=57", 32'h0000_5700, 32'h57f9_ae57);
    endtask

    task automatic t_known;
        apply("R8 col db135345", 32'hdb13_5345, 32'h8e4d_a1bc);
        apply("R8 col f20a225c", 32'hf20a_225c, 32'h9fdc_589d);
        apply("R4 col 01010101", 32'h0101_0101, 32'h0101_0101);
        apply("R4 col c6c6c6c6", 32'hc6c6_c6c6, 32'hc6c6_c6c6);
        apply("R4 col d4d4d4d5", 32'hd4d4_d4d5, 32'hd5d5_d7d6);
        apply("R4 col 2d26314c", 32'h2d26_314c, 32'h4d7e_bdf8);
        apply("R4 col zero", 32'h0000_0000, 32'h0000_0000);
    endtask

    task automatic t_stream;
        logic [31:0] vec [0:7];
        for (int i = 0; i < 8; i++) vec[i] = 32'h9e37_79b9 * (i + 3) ^ (32'h1234_5678 << i);
        for (int i = 0; i <= 8; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R7 stream valid", {31'd0, mix_valid_o}, 32'd1);
                check("R7 stream data", mix_data_o, model(vec[i-1]));
            end
            if (i < 8) begin
                col_valid_i = 1'b1;
                col_data_i  = vec[i];
            end else begin
                col_valid_i = 1'b0;
                col_data_i  = 32'hdead_beef;
            end
        end
        @(negedge clk);
        check("R5 stream end valid", {31'd0, mix_valid_o}, 32'd0);
        check("R6 stream end hold", mix_data_o, model(vec[7]));
    endtask

    initial begin
        t_reset();
        t_single_byte();
        t_known();
        t_stream();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule